// File: doc/BRIEF.md
# Two-Wire Bus Slave Read-Path Controller

This block is the target side of a two-wire serial bus (SMBus / I2C style) for transfers in which a bus master reads from the device. It watches the synchronized clock and data lines and recognizes START and STOP conditions. It collects the address byte most significant bit first and compares its upper seven bits against a programmable slave address. The lowest bit of the byte is the direction bit, and the block only responds when it reads 1 (a read request).

Every decision goes to a host through an interrupt flag and a small set of register-style strobes. The host chooses in advance, through a select input, whether the address is acknowledged. After the acknowledge clock the block raises its interrupt and holds the clock line low until the host clears the flag. The host loads the data to send before it clears the flag, and may do both in the same cycle. The block then shifts that byte out and samples the master's acknowledge bit. If the host clears the flag without loading data, the block stops transmitting and releases the bus.

A 4-bit status vector reports the master flag (always 0 here), transmit mode, START seen and STOP seen. An error flag records a data load made after the master has declined further data.

Top module: `smbus_rd_slave`

## Requirements
- R1: After reset, irq, ackReq, txErr, sdaOe and sclOe are 0, and status is 4'b0000.
- R2: status[3] is always 0. status[1] is set by a START and cleared by a STOP. status[0] is set by a STOP and cleared by a START. Both are never 1 together.
- R3: Take an address byte whose bits 7..1, sent MSB first, equal slaveAddr and whose bit 0 is 1 (read), with inhibit low. For that byte the block drives SDA low during the 9th clock when ackSel is 1. irq and ackReq stay 0 after the 8th clock and become 1 only after the falling edge of the 9th clock.
- R4: With ackSel 0, a matching read address leaves SDA released in the 9th clock but still raises irq and ackReq. After the host clears irq, the block neither drives SDA nor raises irq until the next START. A repeated START with ackSel 1 is acknowledged again.
- R5: An address byte with different bits 7..1, or with bit 0 equal to 0 (write), or any address byte received while inhibit is high, leaves SDA released in the 9th clock and raises no interrupt.
- R6: A loaded byte goes out on SDA MSB first. The bit is driven as a low when it is 0 and released when it is 1. sdaOe changes only while SCL is low.
- R7: status[2] (transmit mode) becomes 1 when irq is cleared with a data byte loaded. It stays 1 through the rest of the transfer, including after a master NACK, and returns to 0 on STOP or START.
- R8: After each transmitted byte, irq becomes 1 after the falling edge of the 9th clock. masterAck then gives the master's bit from that clock: 1 means ACK (SDA low), 0 means NACK.
- R9: A data load while irq is 1 after a master NACK sets txErr. txErr stays 1 until the next START clears it.
- R10: If irq is cleared after an acknowledged byte and no data has been loaded since the last START or the last transmitted byte, status[2] goes to 0. SDA then stays released, so the master reads 8'hFF, and irq stays 0 until the next START.
- R11: irq, once set, stays 1 until clrSi is pulsed. sclOe holds SCL low from the cycle after irq rises until the cycle after irq falls.
- R12: A data load and a clrSi pulse in the same cycle transmit the byte loaded in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sclOe | output | 1 | 1 pulls the clock line low (clock hold) |
| sdaOe | output | 1 | 1 pulls the data line low |
| slaveAddr | input | 7 | Programmable 7-bit slave address |
| inhibit | input | 1 | 1 disables all slave responses |
| ackSel | input | 1 | 1 acknowledges a matching address, 0 declines it |
| dataWrEn | input | 1 | Host load strobe for the transmit data register |
| dataWr | input | 8 | Byte loaded by the host |
| clrSi | input | 1 | Host pulse that clears the interrupt flag |
| irq | output | 1 | Interrupt flag |
| ackReq | output | 1 | Set together with irq after an address byte |
| status | output | 4 | {master (0), transmit mode, START seen, STOP seen} |
| txErr | output | 1 | Data loaded after a master NACK |
| masterAck | output | 1 | Last acknowledge bit from the master, 1 = ACK |

## Verification
The host's data load and its interrupt clear can land in the same clock cycle. The block has to treat the byte as loaded at the moment it decides between transmitting and falling back. The bench drives a full 256-byte read with every second byte loaded and released in one cycle. Each received value is compared with a byte sequence computed in the bench, so a loss of the same-cycle load shows up as 8'hFF or as a stale value. The same overlap of load and a still-set flag after a master NACK is used to judge the error flag.

// File: rtl/smbus_rd_pkg.sv
package smbus_rd_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic flushData;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WAIT,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } rdState_t;

  localparam int STATUS_W = 4;

endpackage

// File: rtl/smbus_rd_datapath.sv
module smbus_rd_datapath
  import smbus_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-2:0] slaveAddr,
  input  logic              dataWrEn,
  input  logic [BYTE_W-1:0] dataWr,
  input  dpCtl_t            ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrHit,
  output logic              shMsb,
  output logic              hasData
);

  logic [SYNC_N-1:0] sclPipe, sdaPipe;
  logic              sclS, sdaS, sclP, sdaP;
  logic [BYTE_W-1:0] shReg, dataReg, nextData;
  logic              loaded;

  // synchronizers, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_N-1];
  assign sdaS     = sdaPipe[SYNC_N-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sdaBit   = sdaS;

  // bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          bitCnt <= '0;
    else if (ctl.clrCnt)                bitCnt <= '0;
    else if (ctl.shiftIn | ctl.shiftOut) bitCnt <= bitCnt + 1'b1;
  end

  // host data register
  assign nextData = dataWrEn ? dataWr : dataReg;
  assign hasData  = loaded | dataWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      loaded  <= 1'b0;
    end else begin
      dataReg <= nextData;
      if (ctl.loadTx | ctl.flushData) loaded <= 1'b0;
      else if (dataWrEn)              loaded <= 1'b1;
    end
  end

  // shift register, shared by address receive and data transmit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (ctl.loadTx)   shReg <= nextData;
    else if (ctl.shiftIn)  shReg <= {shReg[BYTE_W-2:0], sdaS};
    else if (ctl.shiftOut) shReg <= {shReg[BYTE_W-2:0], 1'b0};
  end

  assign shMsb   = shReg[BYTE_W-1];
  assign addrHit = shReg[0] && (shReg[BYTE_W-1:1] == slaveAddr);

endmodule

// File: rtl/smbus_rd_ctrl.sv
module smbus_rd_ctrl
  import smbus_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclRise,
  input  logic                sclFall,
  input  logic                startDet,
  input  logic                stopDet,
  input  logic                sdaBit,
  input  logic [CNT_W-1:0]    bitCnt,
  input  logic                addrHit,
  input  logic                shMsb,
  input  logic                hasData,
  input  logic                inhibit,
  input  logic                ackSel,
  input  logic                dataWrEn,
  input  logic                clrSi,
  output dpCtl_t              ctl,
  output logic                sdaOe,
  output logic                sclOe,
  output logic                irq,
  output logic                ackReq,
  output logic [STATUS_W-1:0] status,
  output logic                txErr,
  output logic                masterAck
);

  localparam logic [CNT_W-1:0] ADDR_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  rdState_t state;
  logic     ackGiven, addrNack, mstNack, txMode, staF, stoF;
  logic     hostGo, nackPending;

  assign hostGo      = (state == ST_WAIT) && clrSi;
  assign nackPending = addrNack | mstNack;

  always_comb begin
    ctl           = '0;
    ctl.flushData = startDet;
    ctl.clrCnt    = startDet | hostGo;
    ctl.shiftIn   = (state == ST_ADDR) && sclRise && (bitCnt != ADDR_DONE) && !startDet;
    ctl.loadTx    = hostGo && !nackPending && hasData;
    ctl.shiftOut  = (state == ST_TX) && sclFall && (bitCnt != LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irq      <= 1'b0;
      ackReq   <= 1'b0;
      ackGiven <= 1'b0;
      addrNack <= 1'b0;
      mstNack  <= 1'b0;
      txMode   <= 1'b0;
      staF     <= 1'b0;
      stoF     <= 1'b0;
      txErr    <= 1'b0;
      sclOe    <= 1'b0;
    end else begin
      sclOe <= irq;
      if (dataWrEn && irq && mstNack) txErr <= 1'b1;
      if (startDet) begin
        state  <= ST_ADDR;
        staF   <= 1'b1;
        stoF   <= 1'b0;
        txMode <= 1'b0;
        txErr  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        staF   <= 1'b0;
        stoF   <= 1'b1;
        txMode <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (sclFall && bitCnt == ADDR_DONE) begin
            if (addrHit && !inhibit) begin
              state    <= ST_ADDR_ACK;
              ackGiven <= ackSel;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            irq      <= 1'b1;
            ackReq   <= 1'b1;
            addrNack <= ~ackGiven;
            mstNack  <= 1'b0;
            state    <= ST_WAIT;
          end
          ST_WAIT: if (clrSi) begin
            irq    <= 1'b0;
            ackReq <= 1'b0;
            if (nackPending) begin
              state <= ST_SKIP;
            end else if (hasData) begin
              state  <= ST_TX;
              txMode <= 1'b1;
            end else begin
              state  <= ST_SKIP;
              txMode <= 1'b0;
            end
          end
          ST_TX: if (sclFall && bitCnt == LAST_BIT) state <= ST_TX_ACK;
          ST_TX_ACK: begin
            if (sclRise) mstNack <= sdaBit;
            if (sclFall) begin
              irq   <= 1'b1;
              state <= ST_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe     = ((state == ST_ADDR_ACK) && ackGiven) || ((state == ST_TX) && !shMsb);
  assign status    = {1'b0, txMode, staF, stoF};
  assign masterAck = ~mstNack;

endmodule

// File: rtl/smbus_rd_slave.sv
module smbus_rd_slave
  import smbus_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [BYTE_W-2:0] slaveAddr,
  input  logic              inhibit,
  input  logic              ackSel,
  input  logic              dataWrEn,
  input  logic [BYTE_W-1:0] dataWr,
  input  logic              clrSi,
  output logic              irq,
  output logic              ackReq,
  output logic [3:0]        status,
  output logic              txErr,
  output logic              masterAck
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  dpCtl_t           ctl;
  logic             sclRise, sclFall, startDet, stopDet, sdaBit;
  logic [CNT_W-1:0] bitCnt;
  logic             addrHit, shMsb, hasData;

  smbus_rd_datapath #(.BYTE_W(BYTE_W), .SYNC_N(SYNC_N), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .slaveAddr(slaveAddr), .dataWrEn(dataWrEn), .dataWr(dataWr), .ctl(ctl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .sdaBit(sdaBit), .bitCnt(bitCnt), .addrHit(addrHit), .shMsb(shMsb),
    .hasData(hasData)
  );

  smbus_rd_ctrl #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit), .bitCnt(bitCnt),
    .addrHit(addrHit), .shMsb(shMsb), .hasData(hasData), .inhibit(inhibit),
    .ackSel(ackSel), .dataWrEn(dataWrEn), .clrSi(clrSi), .ctl(ctl),
    .sdaOe(sdaOe), .sclOe(sclOe), .irq(irq), .ackReq(ackReq), .status(status),
    .txErr(txErr), .masterAck(masterAck)
  );

endmodule

// File: rtl/smbus_rd_slave_chk.sv
module smbus_rd_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       irq,
  input logic       ackReq,
  input logic [3:0] status,
  input logic       txErr,
  input logic       clrSi
);

  p_sta_sto_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(status[1] && status[0]));

  p_ackreq_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackReq) |-> irq);

  p_sda_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  p_err_txmode_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txErr) |-> status[2]);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrSi) |=> irq);

endmodule

bind smbus_rd_slave smbus_rd_slave_chk i_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .irq(irq),
  .ackReq(ackReq), .status(status), .txErr(txErr), .clrSi(clrSi)
);

// File: tb/test_smbus_rd_slave.sv
module test_smbus_rd_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WATCHDOG   = 190000;
  localparam logic [6:0] OWN_ADDR = 7'h2D;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mSclLow = 1'b0, mSdaLow = 1'b0;
  logic       sclOe, sdaOe, sclLine, sdaLine;
  logic [6:0] slaveAddr = OWN_ADDR;
  logic       inhibit = 1'b0, ackSel = 1'b1, dataWrEn = 1'b0, clrSi = 1'b0;
  logic [7:0] dataWr = 8'h00;
  logic       irq, ackReq, txErr, masterAck;
  logic [3:0] status;
  int         nRun = 0, nFail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = !(mSclLow || sclOe);
  assign sdaLine = !(mSdaLow || sdaOe);

  smbus_rd_slave i_smbus_rd_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .slaveAddr(slaveAddr), .inhibit(inhibit),
    .ackSel(ackSel), .dataWrEn(dataWrEn), .dataWr(dataWr), .clrSi(clrSi),
    .irq(irq), .ackReq(ackReq), .status(status), .txErr(txErr),
    .masterAck(masterAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (!sclLine) @(negedge clk);
  endtask

  task automatic clockBit(input logic drv, output logic got);
    mSdaLow = ~drv;
    waitClk(Q);
    mSclLow = 1'b0;
    waitSclHigh();
    waitClk(Q);
    got = sdaLine;
    waitClk(Q);
    mSclLow = 1'b1;
    waitClk(Q);
  endtask

  task automatic startCond();
    mSdaLow = 1'b0;
    waitClk(Q);
    mSclLow = 1'b0;
    waitSclHigh();
    waitClk(Q);
    mSdaLow = 1'b1;
    waitClk(Q);
    mSclLow = 1'b1;
    waitClk(Q);
  endtask

  task automatic stopCond();
    mSdaLow = 1'b1;
    waitClk(Q);
    mSclLow = 1'b0;
    waitSclHigh();
    waitClk(Q);
    mSdaLow = 1'b0;
    waitClk(Q);
  endtask

  task automatic sendAddr(input logic [7:0] b, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) clockBit(b[i], g);
    clockBit(1'b1, g);
    acked = ~g;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] val);
    logic g;
    val = '0;
    for (int i = 0; i < 8; i++) begin
      clockBit(1'b1, g);
      val = {val[6:0], g};
    end
    clockBit(~giveAck, g);
  endtask

  task automatic hostWrite(input logic [7:0] v);
    dataWr = v; dataWrEn = 1'b1;
    waitClk(1);
    dataWrEn = 1'b0;
  endtask

  task automatic hostClear();
    clrSi = 1'b1;
    waitClk(1);
    clrSi = 1'b0;
  endtask

  task automatic hostBoth(input logic [7:0] v);
    dataWr = v; dataWrEn = 1'b1; clrSi = 1'b1;
    waitClk(1);
    dataWrEn = 1'b0; clrSi = 1'b0;
  endtask

  function automatic logic [7:0] patt(input int k);
    return 8'((k * 167 + 3) & 255);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic       a, g;
    logic [7:0] v;
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 ackReq", ackReq, 0);
    chk("R1 status", status, 4'b0000);
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 sclOe", sclOe, 0);
    chk("R1 txErr", txErr, 0);

    // ---- long read: every byte value, R12 on odd bytes ----
    startCond();
    chk("R2 start status", status, 4'b0010);
    for (int i = 7; i >= 0; i--) clockBit(((8'(OWN_ADDR) << 1) | 8'h01) >> i, g);
    chk("R3 no irq after 8 bits", irq, 0);
    clockBit(1'b1, g);
    chk("R3 address acked", g, 0);
    chk("R3 irq after ack clock", irq, 1);
    chk("R3 ackReq", ackReq, 1);
    chk("R11 scl held", sclOe, 1);
    hostWrite(patt(0));
    waitClk(3);
    chk("R11 irq kept", irq, 1);
    hostClear();
    waitClk(2);
    chk("R11 scl released", sclOe, 0);
    chk("R7 txmode", status[2], 1);
    chk("R3 ackReq cleared", ackReq, 0);
    for (int k = 0; k < 256; k++) begin
      readByte(k != 255, v);
      chk((k % 2 == 1) ? "R12 byte" : "R6 byte", v, patt(k));
      chk("R8 irq", irq, 1);
      chk("R8 masterAck", masterAck, (k != 255) ? 1 : 0);
      if (k != 255) begin
        if (k % 2 == 0) hostBoth(patt(k + 1));
        else begin
          hostWrite(patt(k + 1));
          hostClear();
        end
      end
    end
    chk("R9 no err yet", txErr, 0);
    hostWrite(8'h77);
    chk("R9 err set", txErr, 1);
    hostClear();
    waitClk(2);
    chk("R7 txmode after nack", status[2], 1);
    stopCond();
    waitClk(2);
    chk("R2 stop status", status, 4'b0001);
    chk("R9 err held", txErr, 1);

    // ---- declined address, then repeated START ----
    ackSel = 1'b0;
    startCond();
    chk("R9 err cleared by start", txErr, 0);
    sendAddr({OWN_ADDR, 1'b1}, a);
    chk("R4 nack on address", a, 0);
    chk("R4 irq", irq, 1);
    chk("R4 ackReq", ackReq, 1);
    hostClear();
    readByte(1'b1, v);
    chk("R4 bus released", v, 8'hFF);
    chk("R4 no irq", irq, 0);
    ackSel = 1'b1;
    startCond();
    sendAddr({OWN_ADDR, 1'b1}, a);
    chk("R4 acked after restart", a, 1);
    chk("R4 irq after restart", irq, 1);
    hostClear();
    waitClk(2);
    chk("R10 txmode fallback", status[2], 0);
    readByte(1'b1, v);
    chk("R10 reads ones", v, 8'hFF);
    chk("R10 no irq", irq, 0);
    stopCond();

    // ---- inhibit and full address sweep ----
    inhibit = 1'b1;
    startCond();
    sendAddr({OWN_ADDR, 1'b1}, a);
    chk("R5 inhibit no ack", a, 0);
    chk("R5 inhibit no irq", irq, 0);
    stopCond();
    inhibit = 1'b0;
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      logic       exp;
      bb  = 8'(b);
      exp = (bb[7:1] == OWN_ADDR) && bb[0];
      startCond();
      sendAddr(bb, a);
      chk("R5 sweep ack", a, exp);
      chk("R5 sweep irq", irq, exp);
      if (irq) hostClear();
      stopCond();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule